// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block performs one arithmetic, logic or shift operation per issued cycle on two operands that are either 8 or 16 bits wide. Alongside the result it maintains a six-bit status register: carry, parity, auxiliary (nibble) carry, zero, sign and overflow. The flag semantics are the ones a classic accumulator-style integer core uses. Only the flags an operation defines are written. A per-flag write mask reports which bits the last operation touched.

An operation is presented on `op`, `wide`, `opa`, `opb` and `carry_in` with `issue` high. On the next rising clock edge the block registers the result, the write mask and the written flags. Transfer operations and zero-count shifts return a value but leave every flag bit as it was. When `issue` is low, all outputs hold and the mask reads zero.

Top module: `bw_alu`

## Requirements
- R1: While `rst_n` is low, `res`, all six flags and `flag_we` are zero.
- R2: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, AND=4, OR=5, XOR=6, SHL=7, SHR=8 and PASS=9. Codes 10 to 15 behave as PASS. ADD and SUB compute opa+opb and opa-opb, and ignore `carry_in`. ADC and SBB also add or subtract `carry_in`. Each result is truncated to the selected width.
- R3: After an arithmetic operation, `cf` holds the carry out of the top bit of the selected width for additions, and the borrow for subtractions.
- R4: `pf` is 1 when bits 7..0 of the result hold an even number of ones, and 0 otherwise, at both widths.
- R5: After an arithmetic operation, `af` holds the carry or borrow from bit 3 into bit 4.
- R6: `zf` is 1 exactly when the result at the selected width is zero.
- R7: `sf` copies bit 15 of the result for word width and bit 7 for byte width.
- R8: After an arithmetic operation, `of` is 1 when the two's-complement result does not fit the selected width. AND, OR and XOR clear `cf`, `of` and `af`.
- R9: With `wide` low, only bits 7..0 of the operands are used, and `res[15:8]` is zero. Carry, sign and overflow come from bit 7.
- R10: For SHL and SHR the count is `opb[4:0]`, and zeros are shifted in. `cf` takes the last bit shifted out, which is zero once the count exceeds the width. `af` and `of` are cleared.
- R11: A shift with a count of zero returns `opa` at the selected width, leaves all flags unchanged and reports a zero mask.
- R12: PASS returns `opb` at the selected width, leaves all flags unchanged and reports a zero mask.
- R13: A cycle with `issue` low changes neither `res` nor any flag, and clears `flag_we`.
- R14: `flag_we` bit order is carry 0, parity 1, auxiliary 2, zero 3, sign 4, overflow 5. Arithmetic, logic and non-zero shifts set all six bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Operation valid this cycle |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| opa | input | 16 | First operand, shift source |
| opb | input | 16 | Second operand, shift count, transfer source |
| carry_in | input | 1 | Incoming carry or borrow for ADC/SBB |
| res | output | 16 | Registered result |
| cf | output | 1 | Carry flag |
| pf | output | 1 | Parity flag |
| af | output | 1 | Auxiliary carry flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Overflow flag |
| flag_we | output | 6 | Flags written by the last cycle |

## Verification
The assertions assume that `issue`, `op`, `wide` and the operands are stable and known at each rising edge once reset is released. They also assume that reset is held for at least one edge, so that every `$stable` comparison is made against a registered value. The stimulus changes inputs only on falling edges and keeps `issue` low during reset. It draws op codes from the full 4-bit range, so the unused codes are covered as well. Shift counts are drawn from the full 5-bit range, which covers zero counts, counts equal to the width and counts beyond it.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW     = 16;
  localparam int HW     = DW / 2;
  localparam int CNT_W  = 5;
  localparam int FLAG_N = 6;

  // flag bit positions in the write mask and flag vector
  localparam int FI_C = 0;
  localparam int FI_P = 1;
  localparam int FI_A = 2;
  localparam int FI_Z = 3;
  localparam int FI_S = 4;
  localparam int FI_O = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_AND  = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6,
    OP_SHL  = 4'd7, OP_SHR = 4'd8, OP_PASS = 4'd9
  } alu_op_e;

  function automatic logic even_par8(input logic [7:0] v);
    return ~^v;
  endfunction

  function automatic logic signed_ovf(input logic sa, input logic sb,
                                      input logic sr, input logic sub);
    // operands of like sign (add) or unlike sign (sub) flipping the result
    return sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          cin,
  input  logic          wide,
  output logic [DW-1:0] sum,
  output logic          co,
  output logic          half,
  output logic          ovf
);
  logic [DW-1:0] bx;
  logic          c0;
  logic [DW:0]   s_w;
  logic [HW:0]   s_b;

  assign bx  = sub ? ~b : b;
  assign c0  = sub ? ~cin : cin;
  assign s_w = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, c0};
  assign s_b = {1'b0, a[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, c0};

  always_comb begin
    if (wide) begin
      sum = s_w[DW-1:0];
      co  = s_w[DW] ^ sub;
      ovf = signed_ovf(a[DW-1], b[DW-1], s_w[DW-1], sub);
    end else begin
      sum = {{(DW-HW){1'b0}}, s_b[HW-1:0]};
      co  = s_b[HW] ^ sub;
      ovf = signed_ovf(a[HW-1], b[HW-1], s_b[HW-1], sub);
    end
    half = a[4] ^ b[4] ^ sum[4];
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
(
  input  logic [DW-1:0]    opd,
  input  logic [CNT_W-1:0] cnt,
  input  logic             right,
  input  logic             wide,
  output logic [DW-1:0]    shres,
  output logic             shout
);
  logic [2*DW-1:0] tl;
  logic [DW:0]     tr;

  // operand arrives already zero-extended above the selected width
  assign tl = {{DW{1'b0}}, opd} << cnt;
  assign tr = {opd, 1'b0} >> cnt;

  always_comb begin
    if (right) begin
      shres = tr[DW:1];
      shout = tr[0];
    end else if (wide) begin
      shres = tl[DW-1:0];
      shout = tl[DW];
    end else begin
      shres = {{(DW-HW){1'b0}}, tl[HW-1:0]};
      shout = tl[HW];
    end
  end
endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [3:0]    op,
  input  logic          wide,
  input  logic [15:0]   opa,
  input  logic [15:0]   opb,
  input  logic          carry_in,
  output logic [15:0]   res,
  output logic          cf,
  output logic          pf,
  output logic          af,
  output logic          zf,
  output logic          sf,
  output logic          of,
  output logic [5:0]    flag_we
);
  alu_op_e            opc;
  logic [DW-1:0]      a_w, b_w, as_sum, sh_res, r_nx;
  logic               as_co, as_half, as_ovf, sh_cf;
  logic               is_arith, is_logic, is_shift, is_sub, use_cin, shift_zero;
  logic [FLAG_N-1:0]  f_nx, m_nx, flags_q, we_q;
  logic [DW-1:0]      res_q;

  assign opc        = alu_op_e'(op);
  assign a_w        = wide ? opa : {{(DW-HW){1'b0}}, opa[HW-1:0]};
  assign b_w        = wide ? opb : {{(DW-HW){1'b0}}, opb[HW-1:0]};
  assign is_arith   = (opc == OP_ADD) || (opc == OP_ADC) || (opc == OP_SUB) || (opc == OP_SBB);
  assign is_logic   = (opc == OP_AND) || (opc == OP_OR) || (opc == OP_XOR);
  assign is_shift   = (opc == OP_SHL) || (opc == OP_SHR);
  assign is_sub     = (opc == OP_SUB) || (opc == OP_SBB);
  assign use_cin    = ((opc == OP_ADC) || (opc == OP_SBB)) && carry_in;
  assign shift_zero = is_shift && (opb[CNT_W-1:0] == '0);

  alu_addsub u_as (
    .a(a_w), .b(b_w), .sub(is_sub), .cin(use_cin), .wide(wide),
    .sum(as_sum), .co(as_co), .half(as_half), .ovf(as_ovf)
  );

  alu_shift u_sh (
    .opd(a_w), .cnt(opb[CNT_W-1:0]), .right(opc == OP_SHR), .wide(wide),
    .shres(sh_res), .shout(sh_cf)
  );

  always_comb begin
    f_nx = '0;
    m_nx = '0;
    r_nx = b_w;
    if (is_arith) begin
      r_nx       = as_sum;
      f_nx[FI_C] = as_co;
      f_nx[FI_A] = as_half;
      f_nx[FI_O] = as_ovf;
      m_nx       = '1;
    end else if (is_logic) begin
      unique case (opc)
        OP_AND:  r_nx = a_w & b_w;
        OP_OR:   r_nx = a_w | b_w;
        default: r_nx = a_w ^ b_w;
      endcase
      m_nx = '1;
    end else if (is_shift) begin
      if (shift_zero) begin
        r_nx = a_w;
      end else begin
        r_nx       = sh_res;
        f_nx[FI_C] = sh_cf;
        m_nx       = '1;
      end
    end
    f_nx[FI_P] = even_par8(r_nx[7:0]);
    f_nx[FI_Z] = (r_nx == '0);
    f_nx[FI_S] = wide ? r_nx[DW-1] : r_nx[HW-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
      we_q  <= '0;
    end else begin
      we_q <= issue ? m_nx : '0;
      if (issue) res_q <= r_nx;
    end
  end

  for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                   flags_q[gi] <= 1'b0;
      else if (issue && m_nx[gi])   flags_q[gi] <= f_nx[gi];
    end
  end

  assign res     = res_q;
  assign flag_we = we_q;
  assign cf      = flags_q[FI_C];
  assign pf      = flags_q[FI_P];
  assign af      = flags_q[FI_A];
  assign zf      = flags_q[FI_Z];
  assign sf      = flags_q[FI_S];
  assign of      = flags_q[FI_O];

  a_r4_parity: assert property (@(posedge clk) disable iff (!rst_n)
    issue && m_nx[FI_P] |=> pf == ~^res[7:0]);
  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    issue && m_nx[FI_Z] |=> zf == (res == '0));
  a_r7_word_sign: assert property (@(posedge clk) disable iff (!rst_n)
    issue && wide && m_nx[FI_S] |=> sf == res[DW-1]);
  a_r8_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_logic |=> !cf && !of && !af);
  a_r9_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !wide |=> res[DW-1:HW] == '0);
  a_r11_shift_zero: assert property (@(posedge clk) disable iff (!rst_n)
    issue && shift_zero |=> $stable(flags_q) && flag_we == '0);
  a_r12_pass_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !is_arith && !is_logic && !is_shift |=> $stable(flags_q) && flag_we == '0);
  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(res) && $stable(flags_q) && flag_we == '0);
endmodule

// File: tb/sim_bw_alu.sv
`timescale 1ns/1ps
module sim_bw_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        wide = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic        carry_in = 1'b0;
  logic [15:0] res;
  logic        cf, pf, af, zf, sf, of;
  logic [5:0]  flag_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [5:0]  mdl_fl = '0;   // {of,sf,zf,af,pf,cf}
  logic [15:0] mdl_res = '0;

  always #2 clk = ~clk;

  bw_alu u0 (.clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .wide(wide),
             .opa(opa), .opb(opb), .carry_in(carry_in), .res(res), .cf(cf),
             .pf(pf), .af(af), .zf(zf), .sf(sf), .of(of), .flag_we(flag_we));

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference: returns result, new flags, write mask
  task automatic ref_op(input int o, input bit w, input int a, input int b,
                        input bit ci, output int r, output logic [5:0] fl,
                        output logic [5:0] m);
    int W = w ? 16 : 8;
    int msk = (1 << W) - 1;
    int half = 1 << (W - 1);
    int A = a & msk, B = b & msk, c, s, sA, sB, sr, n, ones;
    bit c_f = 0, a_f = 0, o_f = 0;
    fl = mdl_fl;
    m = 6'h3F;
    sA = (A >= half) ? A - 2 * half : A;
    sB = (B >= half) ? B - 2 * half : B;
    c = (o == 1 || o == 3) ? int'(ci) : 0;
    case (o)
      0, 1: begin
        s = A + B + c; r = s & msk; c_f = s > msk;
        a_f = ((A & 15) + (B & 15) + c) > 15;
        sr = sA + sB + c; o_f = (sr >= half) || (sr < -half);
      end
      2, 3: begin
        s = A - B - c; r = s & msk; c_f = s < 0;
        a_f = ((A & 15) - (B & 15) - c) < 0;
        sr = sA - sB - c; o_f = (sr >= half) || (sr < -half);
      end
      4: r = A & B;
      5: r = A | B;
      6: r = A ^ B;
      7, 8: begin
        n = b & 31; r = A;
        if (n == 0) m = 6'h00;
        for (int i = 0; i < n; i++) begin
          if (o == 7) begin c_f = (r >> (W - 1)) & 1; r = (r << 1) & msk; end
          else        begin c_f = r & 1;              r = r >> 1;         end
        end
      end
      default: begin r = B; m = 6'h00; end
    endcase
    if (m != 0) begin
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
      fl = {o_f, ((r >> (W - 1)) & 1) == 1, r == 0, a_f, (ones % 2) == 0, c_f};
    end
  endtask

  function automatic string res_tag(input int o);
    if (o <= 3) return "R2";
    if (o <= 6) return "R8";
    if (o <= 8) return "R10";
    return "R12";
  endfunction

  task automatic do_op(input int o, input bit w, input int a, input int b,
                       input bit ci, input string rtag);
    int er; logic [5:0] ef, em;
    @(negedge clk);
    op = o[3:0]; wide = w; opa = a[15:0]; opb = b[15:0]; carry_in = ci; issue = 1'b1;
    ref_op(o, w, a, b, ci, er, ef, em);
    @(negedge clk);
    issue = 1'b0;
    mdl_fl = ef; mdl_res = er[15:0];
    check(res == er[15:0], (rtag == "") ? res_tag(o) : rtag, "res", res, er);
    check(cf == ef[0], "R3", "cf", cf, ef[0]);
    check(pf == ef[1], "R4", "pf", pf, ef[1]);
    check(af == ef[2], "R5", "af", af, ef[2]);
    check(zf == ef[3], "R6", "zf", zf, ef[3]);
    check(sf == ef[4], "R7", "sf", sf, ef[4]);
    check(of == ef[5], "R8", "of", of, ef[5]);
    check(flag_we == em, "R14", "flag_we", flag_we, em);
  endtask

  task automatic idle_step();
    @(negedge clk);
    issue = 1'b0; op = 4'($urandom); opa = 16'($urandom); opb = 16'($urandom);
    @(negedge clk);
    check(res == mdl_res && {of, sf, zf, af, pf, cf} == mdl_fl && flag_we == 0,
          "R13", "idle hold", {res, of, sf, zf, af, pf, cf}, {mdl_res, mdl_fl});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(res == 0 && {of, sf, zf, af, pf, cf} == 0 && flag_we == 0, "R1",
          "reset state", {res, of, sf, zf, af, pf, cf, flag_we}, 0);
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    do_op(6, 1, 16'h5678, 16'h1234, 0, "R8");        // 444Ch
    check(res == 16'h444C, "R8", "xor value", res, 16'h444C);
    do_op(2, 0, 16'h0050, 16'h0070, 0, "R9");        // E0, borrow, sign
    check(cf && sf && !of && !af, "R9", "byte sub flags", {cf, sf, of, af}, 4'b1100);
    do_op(0, 0, 16'hAB7F, 16'h1201, 0, "R9");        // 80h, OF and AF from bit 7 / 3
    check(of && af && !cf && res == 16'h0080, "R9", "byte add ovf", {of, af, cf}, 3'b110);
    do_op(0, 1, 16'hFFFF, 16'h0001, 0, "R3");        // wraps to zero
    do_op(1, 1, 16'h1000, 16'h0001, 1, "R2");        // ADC uses carry
    do_op(0, 1, 16'h1000, 16'h0001, 1, "R2");        // ADD ignores carry
    do_op(3, 1, 16'h8000, 16'h0000, 1, "R2");        // SBB, signed overflow
    do_op(7, 1, 16'h8001, 16'h0000, 0, "R11");       // count zero keeps flags
    do_op(8, 0, 16'h0081, 16'h0001, 0, "R10");       // byte shr 1
    do_op(7, 0, 16'h0001, 16'h0008, 0, "R10");       // shift equals width
    do_op(7, 1, 16'hFFFF, 16'h0014, 0, "R10");       // beyond width
    do_op(9, 1, 16'h0000, 16'hBEEF, 1, "R12");
    do_op(13, 0, 16'h0000, 16'h12FF, 0, "R12");      // unused code
    idle_step();

    for (int k = 0; k < 600; k++) begin
      if (($urandom % 5) == 0) idle_step();
      else do_op(int'($urandom % 16), 1'($urandom), int'($urandom & 16'hFFFF),
                 int'($urandom & 16'hFFFF), 1'($urandom), "");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule